// File: doc/BRIEF.md
# SPI Register Write Target

This block is an SPI target that receives register-write frames from an external host and turns each received data byte into a parallel write on a local register bus in the system clock domain. The host drives an active-low chip select, a serial clock and a serial data input. The serial data output is never driven. Two configuration inputs select the serial clock idle level and the sampling phase, so all four SPI clock modes are available.

A frame is sent most significant bit first and has four parts: a direction bit, a 14-bit register address, a burst flag, and then one or more 8-bit data bytes. Each completed data byte produces a single-cycle write strobe with its address and data on the local side. In burst frames the address steps by one after every byte. The serial inputs are brought into the system clock through a synchroniser. Serial clock edges are detected in the system clock domain, so the system clock must run at least four times faster than the serial clock.

Top module: `spi_wr_port`

## Requirements
- R1: Mode selection. With `cfg_cpha`=0 a bit is sampled on the leading serial clock edge, which is the edge that leaves the idle level `cfg_cpol`. With `cfg_cpha`=1 it is sampled on the trailing edge, which returns to `cfg_cpol`. All four combinations deliver the same writes for the same frame.
- R2: Frame layout. Bits arrive MSB first. Bit 0 of the frame is the direction bit, and 0 means write. Frame bits 1 to 14 are the address, A13 first. Bit 15 is the burst flag. The bits after that are data bytes, D7 first. Each write presents that address and byte on `reg_addr` and `reg_wdata`.
- R3: `reg_wr` is high for exactly one system clock cycle for each completed data byte, and never for two cycles in a row.
- R4: With burst flag 0, only the first data byte is written. Later bits are ignored until chip select goes high again.
- R5: With burst flag 1, every completed byte is written. The address rises by one per byte and wraps from 0x3FFF to 0x0000.
- R6: If chip select goes high before a data byte is complete, the partial byte produces no write. Bytes completed earlier in the same frame are still written.
- R7: A frame whose direction bit is 1 produces no write.
- R8: Serial clock transitions while chip select is high produce no write, and they do not disturb the next frame.
- R9: `spi_miso` is 0 and `spi_miso_oe` is 0 at all times.
- R10: After reset, `reg_wr` is 0, and `reg_addr` and `reg_wdata` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| spi_csn | input | 1 | Active-low chip select |
| spi_sclk | input | 1 | Serial clock from host |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, held at 0 |
| spi_miso_oe | output | 1 | Output enable for `spi_miso`, held at 0 |
| reg_addr | output | 14 | Local write address |
| reg_wdata | output | 8 | Local write data |
| reg_wr | output | 1 | One-cycle write strobe |

## Verification
The bench uses the default parameters: a 14-bit address, 8-bit data and two synchroniser stages. The serial clock runs at one eighth of the system clock. With the full 14-bit address, a three-byte burst that starts at 0x3FFE reaches the address wrap. With two synchroniser stages, the gap between the last serial edge and the strobe stays short enough to check each frame directly. Every frame is sent in each of the four clock modes. The frames also cover truncated bytes, read-direction frames and clock activity while chip select is high.

// File: rtl/spi_wr_pkg.sv
package spi_wr_pkg;

    typedef enum logic [1:0] {
        PH_HDR  = 2'd0,
        PH_DATA = 2'd1,
        PH_SKIP = 2'd2
    } phase_e;

endpackage

// File: rtl/spi_wr_sync.sv
module spi_wr_sync #(
    parameter int         N_SIG   = 3,
    parameter int         STAGES  = 2,
    parameter logic [N_SIG-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SIG-1:0] sig_i,
    output logic [N_SIG-1:0] sync_o,
    output logic [N_SIG-1:0] prev_o
);

    localparam int CHAIN_W = STAGES + 1;

    for (genvar g = 0; g < N_SIG; g++) begin : g_bit
        logic [CHAIN_W-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[CHAIN_W-2:0], sig_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {CHAIN_W{RST_VAL[g]}};
            else        chain_q <= chain_d;
        end

        assign sync_o[g] = chain_q[STAGES-1];
        assign prev_o[g] = chain_q[STAGES];
    end

endmodule

// File: rtl/spi_wr_edge.sv
module spi_wr_edge (
    input  logic cfg_cpol,
    input  logic cfg_cpha,
    input  logic csn_s,
    input  logic sclk_s,
    input  logic sclk_prev,
    output logic cs_act,
    output logic sample
);

    logic toggled;
    logic sample_level;

    always_comb begin
        cs_act       = ~csn_s;
        toggled      = sclk_s ^ sclk_prev;
        // leading edge leaves cpol, trailing edge returns to it
        sample_level = cfg_cpol ^ ~cfg_cpha;
        sample       = cs_act & toggled & (sclk_s == sample_level);
    end

endmodule

// File: rtl/spi_wr_decoder.sv
module spi_wr_decoder
    import spi_wr_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sample,
    input  logic              mosi,
    output logic              wr_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);

    localparam int HDR_BITS = ADDR_W + 2;
    localparam int SH_W     = (HDR_BITS > DATA_W) ? HDR_BITS : DATA_W;
    localparam int CNT_W    = $clog2(SH_W + 1);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [SH_W-2:0]   shreg;
        logic [ADDR_W-1:0] cur_addr;
        logic              burst;
        logic              wr;
        logic [ADDR_W-1:0] out_addr;
        logic [DATA_W-1:0] out_data;
    } st_t;

    st_t st_d, st_q;
    logic [HDR_BITS-1:0] hdr_full;
    logic [DATA_W-1:0]   byte_full;

    always_comb begin
        st_d      = st_q;
        st_d.wr   = 1'b0;
        hdr_full  = {st_q.shreg[HDR_BITS-2:0], mosi};
        byte_full = {st_q.shreg[DATA_W-2:0], mosi};

        if (!cs_act) begin
            st_d.phase = PH_HDR;
            st_d.cnt   = '0;
        end else if (sample) begin
            st_d.shreg = {st_q.shreg[SH_W-3:0], mosi};
            st_d.cnt   = st_q.cnt + CNT_W'(1);
            unique case (st_q.phase)
                PH_HDR: begin
                    if (st_q.cnt == CNT_W'(HDR_BITS - 1)) begin
                        st_d.cnt      = '0;
                        st_d.cur_addr = hdr_full[ADDR_W:1];
                        st_d.burst    = hdr_full[0];
                        st_d.phase    = hdr_full[HDR_BITS-1] ? PH_SKIP : PH_DATA;
                    end
                end
                PH_DATA: begin
                    if (st_q.cnt == CNT_W'(DATA_W - 1)) begin
                        st_d.cnt      = '0;
                        st_d.wr       = 1'b1;
                        st_d.out_addr = st_q.cur_addr;
                        st_d.out_data = byte_full;
                        if (st_q.burst) st_d.cur_addr = st_q.cur_addr + ADDR_W'(1);
                        else            st_d.phase    = PH_SKIP;
                    end
                end
                default: begin
                    st_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_HDR;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_o   = st_q.wr;
    assign addr_o = st_q.out_addr;
    assign data_o = st_q.out_data;

    assert_wr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr |=> !st_q.wr);

    assert_single_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wr && !st_q.burst && cs_act) |=> (st_q.phase == PH_SKIP));

    assert_burst_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wr && st_q.burst) |-> (st_q.cur_addr == st_q.out_addr + ADDR_W'(1)));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !st_q.wr);

endmodule

// File: rtl/spi_wr_port.sv
module spi_wr_port #(
    parameter int ADDR_W      = 14,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              spi_csn,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr
);

    localparam int IDX_CSN  = 0;
    localparam int IDX_SCLK = 1;
    localparam int IDX_MOSI = 2;
    localparam int N_SIG    = 3;

    logic [N_SIG-1:0] raw, synced, prev;
    logic             cs_act, sample;

    assign raw = {spi_mosi, spi_sclk, spi_csn};

    spi_wr_sync #(
        .N_SIG   (N_SIG),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (raw),
        .sync_o (synced),
        .prev_o (prev)
    );

    spi_wr_edge u_edge (
        .cfg_cpol  (cfg_cpol),
        .cfg_cpha  (cfg_cpha),
        .csn_s     (synced[IDX_CSN]),
        .sclk_s    (synced[IDX_SCLK]),
        .sclk_prev (prev[IDX_SCLK]),
        .cs_act    (cs_act),
        .sample    (sample)
    );

    spi_wr_decoder #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_act (cs_act),
        .sample (sample),
        .mosi   (synced[IDX_MOSI]),
        .wr_o   (reg_wr),
        .addr_o (reg_addr),
        .data_o (reg_wdata)
    );

    // history bits of chip select and data are not needed
    logic unused_prev;
    assign unused_prev = prev[IDX_CSN] ^ prev[IDX_MOSI];

    assign spi_miso    = 1'b0;
    assign spi_miso_oe = 1'b0;

    assert_sample_needs_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> !synced[IDX_CSN]);

endmodule

// File: tb/sim_spi_wr_port.sv
module sim_spi_wr_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpol = 1'b0, cpha = 1'b0;
    logic        csn = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic        miso, miso_oe;
    logic [13:0] reg_addr;
    logic [7:0]  reg_wdata;
    logic        reg_wr;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int strobe_err = 0;
    int miso_err = 0;
    logic [13:0] wa [16];
    logic [7:0]  wd [16];
    logic        prev_wr = 1'b0;

    localparam time HP = 40ns;

    always #5ns clk = ~clk;

    spi_wr_port u0 (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cpol), .cfg_cpha(cpha),
        .spi_csn(csn), .spi_sclk(sclk), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(miso_oe),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr) begin
                if (wr_cnt < 16) begin
                    wa[wr_cnt] = reg_addr;
                    wd[wr_cnt] = reg_wdata;
                end
                wr_cnt++;
                if (prev_wr) strobe_err++;
            end
            if (miso !== 1'b0 || miso_oe !== 1'b0) miso_err++;
            prev_wr = reg_wr;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_hdr(input logic dir, input logic [13:0] a, input logic b);
        return {dir, a, b};
    endfunction

    task automatic set_mode(input logic p, input logic h);
        cpol = p; cpha = h; sclk = p;
        repeat (10) @(posedge clk);
    endtask

    task automatic send_frame(input logic [15:0] hdr, input logic [31:0] dat, input int ndbits);
        logic [47:0] f;
        f = {hdr, dat};
        wr_cnt = 0;
        csn = 1'b0;
        #(HP);
        for (int i = 0; i < 16 + ndbits; i++) begin
            if (!cpha) begin
                mosi = f[47-i]; #(HP);
                sclk = ~cpol;   #(HP);
                sclk = cpol;
            end else begin
                sclk = ~cpol; mosi = f[47-i]; #(HP);
                sclk = cpol;  #(HP);
            end
        end
        #(HP);
        csn = 1'b1;
        repeat (20) @(posedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R10 reg_wr after reset", int'(reg_wr), 0);
        check("R10 reg_addr after reset", int'(reg_addr), 0);
        check("R10 reg_wdata after reset", int'(reg_wdata), 0);
        check("R9 miso_oe after reset", int'(miso_oe), 0);
    endtask

    task automatic t_modes;
        for (int m = 0; m < 4; m++) begin
            logic [13:0] a;
            logic [7:0]  d;
            a = 14'h1234 ^ 14'(m * 14'h0421);
            d = 8'hA5 + 8'(m * 17);
            set_mode(m[1], m[0]);
            send_frame(mk_hdr(1'b0, a, 1'b0), {d, 24'h0}, 8);
            check($sformatf("R1 R3 write count mode %0d", m), wr_cnt, 1);
            check($sformatf("R2 address mode %0d", m), int'(wa[0]), int'(a));
            check($sformatf("R2 data mode %0d", m), int'(wd[0]), int'(d));
        end
    endtask

    task automatic t_single_extra;
        set_mode(1'b0, 1'b1);
        send_frame(mk_hdr(1'b0, 14'h0ABC, 1'b0), {8'h3C, 8'hC3, 8'h77, 8'h0}, 24);
        check("R4 non-burst writes one byte", wr_cnt, 1);
        check("R4 non-burst address", int'(wa[0]), 'h0ABC);
        check("R4 non-burst data", int'(wd[0]), 'h3C);
    endtask

    task automatic t_burst;
        set_mode(1'b1, 1'b0);
        send_frame(mk_hdr(1'b0, 14'h3FFE, 1'b1), {8'h11, 8'h22, 8'h33, 8'h0}, 24);
        check("R5 burst write count", wr_cnt, 3);
        check("R5 burst addr 0", int'(wa[0]), 'h3FFE);
        check("R5 burst addr 1", int'(wa[1]), 'h3FFF);
        check("R5 burst addr wrap", int'(wa[2]), 'h0000);
        check("R5 burst data 0", int'(wd[0]), 'h11);
        check("R5 burst data 2", int'(wd[2]), 'h33);
    endtask

    task automatic t_abort;
        set_mode(1'b0, 1'b0);
        send_frame(mk_hdr(1'b0, 14'h0100, 1'b0), {8'hF0, 24'h0}, 4);
        check("R6 partial byte no write", wr_cnt, 0);
        set_mode(1'b1, 1'b1);
        send_frame(mk_hdr(1'b0, 14'h0200, 1'b1), {8'h5A, 8'hFF, 16'h0}, 13);
        check("R6 full byte before abort written", wr_cnt, 1);
        check("R6 data of completed byte", int'(wd[0]), 'h5A);
    endtask

    task automatic t_read;
        set_mode(1'b0, 1'b0);
        send_frame(mk_hdr(1'b1, 14'h0321, 1'b1), {8'hAA, 8'h55, 16'h0}, 16);
        check("R7 read frame no write", wr_cnt, 0);
    endtask

    task automatic t_idle_clk;
        set_mode(1'b0, 1'b0);
        wr_cnt = 0;
        for (int i = 0; i < 20; i++) begin
            mosi = i[0];
            sclk = ~sclk; #(HP);
        end
        sclk = 1'b0;
        repeat (10) @(posedge clk);
        check("R8 clock with cs high no write", wr_cnt, 0);
        send_frame(mk_hdr(1'b0, 14'h2468, 1'b0), {8'h9C, 24'h0}, 8);
        check("R8 following frame count", wr_cnt, 1);
        check("R8 following frame data", int'(wd[0]), 'h9C);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        t_reset();
        t_modes();
        t_single_extra();
        t_burst();
        t_abort();
        t_read();
        t_idle_clk();
        check("R3 no back-to-back strobe", strobe_err, 0);
        check("R9 miso stays low and disabled", miso_err, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements): actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule